// File: doc/BRIEF.md
# FIFO Hand-off Lock Controller

This block arbitrates a single mutual-exclusion lock among a parameterised number of requesters. Each requester raises a one-cycle acquire pulse to ask for the lock and a one-cycle release pulse to give it back. A level grant output tells it when it holds the lock. When the lock is free, a request is granted on the following cycle.

Requests that arrive while the lock is taken join a first-in first-out waiting list. When the holder releases, the controller passes the lock straight to the oldest waiter, with no idle cycle in between. The lock is never left open for the waiters to race for, so a waiter only has to watch its grant line and never retries. Grants follow request order, so no requester can starve. When several requesters ask in the same cycle, the lowest index is served first. Misuse does not change any state but sets a sticky error flag: a release from a requester that does not hold the lock, or a repeat request from a requester that already holds the lock or is already waiting.

Top module: `handoff_lock`

## Requirements
- R1: After reset every grant line is low and the error flag is low.
- R2: When the lock is free and the waiting list is empty, a valid acquire pulse from requester i in cycle t raises grant[i] in cycle t+1.
- R3: An acquire from a requester that is neither the holder nor waiting, made while the lock is held, adds it to the back of the waiting list and leaves the grant lines unchanged.
- R4: Valid acquires made in the same cycle are served in ascending index order: if the lock is free, the lowest index is granted and the others are queued lowest first; otherwise all of them are queued lowest first.
- R5: A release by the holder while requesters are waiting moves the grant to the requester at the head of the list in the very next cycle, with no cycle in which all grant lines are low.
- R6: Across any sequence of releases, grants are issued in the order in which the requests were accepted. The waiting list holds up to N entries.
- R7: A release by the holder with an empty waiting list drops all grant lines in the next cycle, unless a valid acquire arrives in the same cycle, in which case that requester is granted under R2 and R4.
- R8: A release pulse from a requester that does not hold the lock has no effect on the grants or the list and sets the error flag.
- R9: An acquire from the current holder or from a requester already waiting has no effect on the grants or the list and sets the error flag.
- R10: At most one grant line is high in any cycle. Bit i of grant belongs to requester i.
- R11: Once set, the error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq | input | N | One-cycle acquire pulse, bit i from requester i |
| rel | input | N | One-cycle release pulse, bit i from requester i |
| grant | output | N | Lock held, bit i for requester i (at most one high) |
| err | output | 1 | Sticky protocol error flag |

## Verification
A corrupted waiting list shows up at the grant lines on the next hand-off. The wrong requester is granted, or the grant drops to zero while requests are still pending. A wrong owner register shows up in the cycle right after its update, as a second grant bit or a grant that moves without a release. Because the reference model is compared on every clock, each of these faults is reported within one cycle of the first release or acquire that exposes it. A missed misuse case shows up as a difference on the error flag in the cycle after the offending pulse.

// File: rtl/handoff_lock.sv
module handoff_lock #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] acq,
  input  logic [N-1:0] rel,
  output logic [N-1:0] grant,
  output logic         err
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);

  logic          own_v, own_v_n;
  logic [IW-1:0] own, own_n;
  logic [IW-1:0] q   [N];
  logic [IW-1:0] q_n [N];
  logic [CW-1:0] q_cnt, q_cnt_n;
  logic [N-1:0]  waiting, waiting_n;
  logic          err_n;
  logic [N-1:0]  held;
  logic          rel_ok, bad;
  logic [N-1:0]  fresh;

  assign held  = own_v ? (N'(1) << own) : '0;
  assign grant = held;
  assign rel_ok = |(rel & held);
  assign fresh  = acq & ~held & ~waiting;
  assign bad    = |(rel & ~held) | |(acq & (held | waiting));

  always_comb begin
    own_v_n   = own_v;
    own_n     = own;
    q_cnt_n   = q_cnt;
    waiting_n = waiting;
    err_n     = err | bad;
    for (int k = 0; k < N; k++) q_n[k] = q[k];

    if (rel_ok) begin
      if (q_cnt != '0) begin
        own_n = q[0];
        waiting_n[q[0]] = 1'b0;
        for (int k = 0; k < N - 1; k++) q_n[k] = q[k+1];
        q_cnt_n = q_cnt - 1'b1;
      end else begin
        own_v_n = 1'b0;
      end
    end

    for (int i = 0; i < N; i++) begin
      if (fresh[i]) begin
        if (!own_v_n) begin
          own_v_n = 1'b1;
          own_n   = IW'(i);
        end else if (q_cnt_n < CW'(N)) begin
          q_n[q_cnt_n[IW-1:0]] = IW'(i);
          waiting_n[i] = 1'b1;
          q_cnt_n = q_cnt_n + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v   <= 1'b0;
      own     <= '0;
      q_cnt   <= '0;
      waiting <= '0;
      err     <= 1'b0;
      for (int k = 0; k < N; k++) q[k] <= '0;
    end else begin
      own_v   <= own_v_n;
      own     <= own_n;
      q_cnt   <= q_cnt_n;
      waiting <= waiting_n;
      err     <= err_n;
      for (int k = 0; k < N; k++) q[k] <= q_n[k];
    end
  end
endmodule

// File: rtl/handoff_lock_chk.sv
module handoff_lock_chk #(
  parameter int N = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N-1:0]            acq,
  input logic [N-1:0]            rel,
  input logic [N-1:0]            grant,
  input logic                    err,
  input logic [$clog2(N+1)-1:0]  cnt
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (grant == '0 && !err)); // R1
  AST_FREE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && acq != '0) |=> grant != '0); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (rel & grant) == '0) |=> grant == $past(grant)); // R3
  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel & grant) != '0 && cnt != '0) |=> (grant != '0 && grant != $past(grant))); // R5
  AST_LIST_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= N); // R6
  AST_EMPTY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel & grant) != '0 && cnt == '0 && acq == '0) |=> grant == '0); // R7
  AST_BAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel & ~grant) != '0) |=> err); // R8
  AST_DUP_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ((acq & grant) != '0) |=> err); // R9
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R11
endmodule

bind handoff_lock handoff_lock_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq(acq), .rel(rel),
  .grant(grant), .err(err), .cnt(q_cnt)
);

// File: tb/handoff_lock_test.sv
module handoff_lock_test;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] acq = '0, rel = '0;
  logic [N-1:0] grant;
  logic err;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  handoff_lock #(.N(N)) uut (.clk(clk), .rst_n(rst_n), .acq(acq), .rel(rel), .grant(grant), .err(err));

  int m_own;
  int m_q[$];
  bit m_err;

  always @(posedge clk) begin
    int o0, nxt;
    bit relv;
    bit [N-1:0] inq, nv;
    if (!rst_n) begin
      m_own = -1; m_q.delete(); m_err = 1'b0;
    end else begin
      o0 = m_own; relv = 1'b0; inq = '0; nv = '0;
      foreach (m_q[k]) inq[m_q[k]] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (rel[i]) begin
          if (i == o0) relv = 1'b1; else m_err = 1'b1;
        end
        if (acq[i]) begin
          if (i == o0 || inq[i]) m_err = 1'b1; else nv[i] = 1'b1;
        end
      end
      if (relv) begin
        if (m_q.size() > 0) begin nxt = m_q.pop_front(); m_own = nxt; end
        else m_own = -1;
      end
      for (int i = 0; i < N; i++)
        if (nv[i]) begin
          if (m_own < 0) m_own = i; else m_q.push_back(i);
        end
    end
  end

  task automatic compare(string tag);
    logic [N-1:0] eg;
    eg = (m_own < 0) ? '0 : (N'(1) << m_own);
    total++;
    if (grant !== eg) begin
      bad++; $display("FAIL %s grant actual=%b expected=%b", tag, grant, eg);
    end
    total++;
    if (err !== m_err) begin
      bad++; $display("FAIL %s err actual=%b expected=%b", tag, err, m_err);
    end
  endtask

  task automatic step(logic [N-1:0] a, logic [N-1:0] r, string tag);
    acq = a; rel = r;
    @(negedge clk);
    acq = '0; rel = '0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    step(8'h04, 8'h00, "R2");
    step(8'h20, 8'h00, "R3");
    step(8'h02, 8'h00, "R3");
    step(8'h81, 8'h00, "R4");
    step(8'h00, 8'h00, "R3");
    step(8'h00, 8'h04, "R5");
    step(8'h00, 8'h20, "R6");
    step(8'h00, 8'h02, "R6");
    step(8'h00, 8'h01, "R6");
    step(8'h00, 8'h80, "R7");
    step(8'h00, 8'h00, "R7");
    step(8'h68, 8'h00, "R4");
    step(8'h00, 8'h10, "R8");
    step(8'h08, 8'h00, "R9");
    step(8'h20, 8'h00, "R9");
    step(8'h00, 8'h00, "R11");
    step(8'h00, 8'h08, "R5");
    step(8'h00, 8'h20, "R5");
    step(8'h00, 8'h40, "R7");
    step(8'h00, 8'h00, "R11");
    do_reset();
    step(8'h00, 8'h01, "R8");
    do_reset();
    step(8'h10, 8'h00, "R2");
    step(8'h02, 8'h10, "R7");
    step(8'hFD, 8'h00, "R6");
    step(8'h00, 8'h02, "R5");
    do_reset();
    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] a, r;
      a = N'($urandom) & N'($urandom) & N'($urandom);
      r = '0;
      if (m_own >= 0 && ($urandom % 3 == 0)) r = N'(1) << m_own;
      if ($urandom % 40 == 0) r = r | (N'(1) << ($urandom % N));
      step(a, r, "R10");
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule